// File: doc/BRIEF.md
# Integer ALU with Barrel Shifter

This block is the combinational execute-stage arithmetic and logic unit of a small load-store RISC core. It takes two 32-bit operands, a 5-bit shift count and a 4-bit function code. In the same cycle it returns a 32-bit result and a flag that is high when that result is all zeros. The function set covers wrapping add and subtract, three bitwise operations (AND, OR and NOR), signed and unsigned less-than compares that return a full-width 0 or 1, and three shifts. The shifts are a left shift that fills with zeros, a right shift that fills with zeros and a right shift that fills with the sign bit.

The caller chooses what feeds the second operand. It can be a register value or a 16-bit immediate sign-extended to 32 bits, which covers -32768 to +32767. Branch logic tests two registers for equality by running a subtract and reading the zero flag. There is no NOT operation: a bitwise inversion is a NOR against a zero operand. The block has no state, no overflow signal and no trap.

Top module: `int_alu`

## Requirements
- R1: Function code 0 returns the bitwise AND of the operands (0x00000DC0 AND 0x00003C00 = 0x00000C00).
- R2: Function code 1 returns the bitwise OR of the operands (0x00000DC0 OR 0x00003C00 = 0x00003DC0).
- R3: Function code 3 returns the bitwise inverse of (A OR B). With B = 0 the result is the inverse of A.
- R4: Function code 2 returns A + B modulo 2^32. There is no overflow indication.
- R5: Function code 6 returns A - B modulo 2^32. There is no overflow indication.
- R6: Function code 7 returns 32'd1 when A < B as two's-complement numbers, and 32'd0 otherwise. For A = 0xFFFFFFFF and B = 1 it returns 1.
- R7: Function code 8 returns 32'd1 when A < B as unsigned magnitudes, and 32'd0 otherwise. For A = 0xFFFFFFFF and B = 1 it returns 0.
- R8: Function code 4 shifts A left by the shift count (0 to 31) and fills the vacated low bits with zeros. B is ignored.
- R9: Function code 5 shifts A right by the shift count (0 to 31) and fills the vacated high bits with zeros. B is ignored.
- R10: Function code 9 shifts A right by the shift count (0 to 31) and fills the vacated high bits with copies of A bit 31. B is ignored.
- R11: Function codes 10 to 15 return zero whatever the operands are.
- R12: The zero flag is high exactly when the 32-bit result is zero. For function code 6 this means it is high exactly when A equals B.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | 32 | First operand; the value that is shifted |
| b_i | input | 32 | Second operand; a register value or a sign-extended immediate |
| shamt_i | input | 5 | Shift count for function codes 4, 5 and 9 |
| op_i | input | 4 | Function code |
| result_o | output | 32 | Result of the selected function |
| zero_o | output | 1 | High when result_o is all zeros |

## Verification
The assertions are immediate checks. They assume that the operands, the shift count and the function code are stable, known values by the time the combinational logic settles, and they compare the result against whatever function code is present at that moment. The bench changes all four inputs together at the falling clock edge. It reads the outputs only after a settling delay, so no check sees a half-updated input set. All 16 function codes are driven, including every unused code. The shift tests sweep every shift count from 0 to 31 with the second operand set to a nonzero value.

// File: rtl/int_alu_pkg.sv
package int_alu_pkg;
  localparam int OP_W = 4;

  typedef enum logic [OP_W-1:0] {
    FN_AND  = 4'd0,
    FN_OR   = 4'd1,
    FN_ADD  = 4'd2,
    FN_NOR  = 4'd3,
    FN_SLL  = 4'd4,
    FN_SRL  = 4'd5,
    FN_SUB  = 4'd6,
    FN_SLT  = 4'd7,
    FN_SLTU = 4'd8,
    FN_SRA  = 4'd9
  } alu_fn_e;
endpackage

// File: rtl/int_alu_addsub.sv
module int_alu_addsub #(
  parameter int DATA_W = 32
) (
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  input  logic              sub,
  output logic [DATA_W-1:0] sum,
  output logic              lt_signed,
  output logic              lt_unsigned
);
  localparam int MSB = DATA_W - 1;

  logic [DATA_W:0]   wide;
  logic [DATA_W-1:0] b_eff;

  always_comb begin
    b_eff = b ^ {DATA_W{sub}};
    wide  = {1'b0, a} + {1'b0, b_eff} + {{DATA_W{1'b0}}, sub};
    sum   = wide[DATA_W-1:0];
    // No carry out of A + ~B + 1 means A is below B as a magnitude.
    lt_unsigned = ~wide[DATA_W];
    // If the signs differ, the negative operand is the smaller one.
    // Otherwise the difference cannot overflow, so its sign bit decides.
    lt_signed = (a[MSB] != b[MSB]) ? a[MSB] : sum[MSB];
  end

  // R6/R7: when the sign bits agree, the signed and unsigned orders agree
  always_comb begin
    if (sub && (a[MSB] == b[MSB]))
      a_r6_r7_same_sign_order: assert (lt_signed == lt_unsigned)
        else $error("signed and unsigned compare disagree on same-sign operands");
  end

  // R7: the borrow matches the magnitude compare
  always_comb begin
    if (sub)
      a_r7_borrow_is_less: assert (lt_unsigned == (a < b))
        else $error("borrow does not match unsigned compare");
  end
endmodule

// File: rtl/int_alu_bitwise.sv
module int_alu_bitwise #(
  parameter int DATA_W = 32
) (
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  output logic [DATA_W-1:0] and_o,
  output logic [DATA_W-1:0] or_o,
  output logic [DATA_W-1:0] nor_o
);
  always_comb begin
    and_o = a & b;
    or_o  = a | b;
    nor_o = ~or_o;
  end
endmodule

// File: rtl/int_alu_shifter.sv
module int_alu_shifter #(
  parameter int DATA_W  = 32,
  parameter int SHAMT_W = $clog2(DATA_W)
) (
  input  logic [DATA_W-1:0]  din,
  input  logic [SHAMT_W-1:0] shamt,
  output logic [DATA_W-1:0]  sll_o,
  output logic [DATA_W-1:0]  srl_o,
  output logic [DATA_W-1:0]  sra_o
);
  localparam int MSB = DATA_W - 1;

  logic [DATA_W-1:0] lft [SHAMT_W+1];
  logic [DATA_W-1:0] rlz [SHAMT_W+1];
  logic [DATA_W-1:0] ras [SHAMT_W+1];
  logic              fill;

  assign fill   = din[MSB];
  assign lft[0] = din;
  assign rlz[0] = din;
  assign ras[0] = din;

  // One stage per shift-count bit; stage k moves the data by 2**k places.
  for (genvar k = 0; k < SHAMT_W; k++) begin : g_stage
    localparam int STEP = 1 << k;
    assign lft[k+1] = shamt[k] ? {lft[k][MSB-STEP:0], {STEP{1'b0}}} : lft[k];
    assign rlz[k+1] = shamt[k] ? {{STEP{1'b0}}, rlz[k][MSB:STEP]}   : rlz[k];
    assign ras[k+1] = shamt[k] ? {{STEP{fill}}, ras[k][MSB:STEP]}   : ras[k];
  end

  assign sll_o = lft[SHAMT_W];
  assign srl_o = rlz[SHAMT_W];
  assign sra_o = ras[SHAMT_W];

  // R8/R9/R10: a zero count passes the data through unchanged
  always_comb begin
    if (shamt == '0)
      a_r8_r9_r10_zero_count: assert ((sll_o == din) && (srl_o == din) && (sra_o == din))
        else $error("zero shift count changed the data");
  end

  // R10: the sign-filling shift keeps the sign bit
  always_comb begin
    a_r10_sign_kept: assert (sra_o[MSB] == din[MSB])
      else $error("sign-filling shift lost the sign bit");
  end

  // R9/R10: the two right shifts differ only where the fill bits go
  always_comb begin
    if (!din[MSB])
      a_r9_r10_positive_same: assert (srl_o == sra_o)
        else $error("right shifts differ on a non-negative value");
  end
endmodule

// File: rtl/int_alu.sv
module int_alu
  import int_alu_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int SHAMT_W = $clog2(DATA_W)
) (
  input  logic [DATA_W-1:0]  a_i,
  input  logic [DATA_W-1:0]  b_i,
  input  logic [SHAMT_W-1:0] shamt_i,
  input  logic [OP_W-1:0]    op_i,
  output logic [DATA_W-1:0]  result_o,
  output logic               zero_o
);
  logic              sub_sel;
  logic [DATA_W-1:0] sum, and_v, or_v, nor_v, sll_v, srl_v, sra_v;
  logic              lt_s, lt_u;

  // Subtract, and both compares, share the single adder.
  assign sub_sel = (op_i == FN_SUB) || (op_i == FN_SLT) || (op_i == FN_SLTU);

  int_alu_addsub #(.DATA_W(DATA_W)) u_addsub (
    .a(a_i), .b(b_i), .sub(sub_sel),
    .sum(sum), .lt_signed(lt_s), .lt_unsigned(lt_u)
  );

  int_alu_bitwise #(.DATA_W(DATA_W)) u_bitwise (
    .a(a_i), .b(b_i), .and_o(and_v), .or_o(or_v), .nor_o(nor_v)
  );

  int_alu_shifter #(.DATA_W(DATA_W), .SHAMT_W(SHAMT_W)) u_shifter (
    .din(a_i), .shamt(shamt_i), .sll_o(sll_v), .srl_o(srl_v), .sra_o(sra_v)
  );

  always_comb begin
    case (op_i)
      FN_AND:  result_o = and_v;
      FN_OR:   result_o = or_v;
      FN_ADD:  result_o = sum;
      FN_NOR:  result_o = nor_v;
      FN_SLL:  result_o = sll_v;
      FN_SRL:  result_o = srl_v;
      FN_SUB:  result_o = sum;
      FN_SLT:  result_o = {{(DATA_W-1){1'b0}}, lt_s};
      FN_SLTU: result_o = {{(DATA_W-1){1'b0}}, lt_u};
      FN_SRA:  result_o = sra_v;
      default: result_o = '0;
    endcase
  end

  assign zero_o = ~|result_o;

  // R12: equality test through subtract
  always_comb begin
    if (op_i == FN_SUB)
      a_r12_sub_equal: assert (zero_o == (a_i == b_i))
        else $error("zero flag does not track operand equality");
  end

  // R6/R7: compare results are 0 or 1
  always_comb begin
    if ((op_i == FN_SLT) || (op_i == FN_SLTU))
      a_r6_r7_flag_width: assert (result_o[DATA_W-1:1] == '0)
        else $error("compare result has high bits set");
  end

  // R3: NOR with a zero operand inverts A
  always_comb begin
    if ((op_i == FN_NOR) && (b_i == '0))
      a_r3_nor_not: assert (result_o == ~a_i)
        else $error("NOR with zero is not an inversion");
  end

  // R11: unused codes give zero
  always_comb begin
    if (op_i > FN_SRA)
      a_r11_unused_zero: assert (zero_o && (result_o == '0))
        else $error("unused code produced a nonzero result");
  end
endmodule

// File: tb/int_alu_test.sv
module int_alu_test;
  localparam int W = 32;

  typedef struct packed {
    logic [3:0]   op;
    logic [W-1:0] a;
    logic [W-1:0] b;
    logic [4:0]   sh;
    logic [W-1:0] exp;
  } vec_t;

  localparam int NV = 27;
  localparam vec_t VEC [NV] = '{
    '{4'd0, 32'h00000DC0, 32'h00003C00, 5'd0,  32'h00000C00}, // R1
    '{4'd0, 32'hFFFF0000, 32'h0000FFFF, 5'd3,  32'h00000000}, // R1
    '{4'd1, 32'h00000DC0, 32'h00003C00, 5'd0,  32'h00003DC0}, // R2
    '{4'd3, 32'h00003C00, 32'h00000000, 5'd0,  32'hFFFFC3FF}, // R3
    '{4'd3, 32'hF0F0F0F0, 32'h0F0F0000, 5'd0,  32'h00000F0F}, // R3
    '{4'd2, 32'hFFFFFFFF, 32'h00000001, 5'd0,  32'h00000000}, // R4
    '{4'd2, 32'h00000005, 32'hFFFFFFFC, 5'd0,  32'h00000001}, // R4
    '{4'd2, 32'h7FFFFFFF, 32'h00000001, 5'd0,  32'h80000000}, // R4
    '{4'd6, 32'h00000003, 32'h00000005, 5'd0,  32'hFFFFFFFE}, // R5
    '{4'd6, 32'h80000000, 32'h00000001, 5'd0,  32'h7FFFFFFF}, // R5
    '{4'd6, 32'h00001234, 32'h00001234, 5'd0,  32'h00000000}, // R5 R12
    '{4'd7, 32'hFFFFFFFF, 32'h00000001, 5'd0,  32'h00000001}, // R6
    '{4'd7, 32'h7FFFFFFF, 32'h80000000, 5'd0,  32'h00000000}, // R6
    '{4'd7, 32'h00000005, 32'h00000005, 5'd0,  32'h00000000}, // R6
    '{4'd7, 32'hFFFF8000, 32'h00007FFF, 5'd0,  32'h00000001}, // R6
    '{4'd7, 32'hFFFFFFFF, 32'hFFFF8000, 5'd0,  32'h00000000}, // R6
    '{4'd8, 32'hFFFFFFFF, 32'h00000001, 5'd0,  32'h00000000}, // R7
    '{4'd8, 32'h7FFFFFFF, 32'h80000000, 5'd0,  32'h00000001}, // R7
    '{4'd4, 32'h00000001, 32'hDEADBEEF, 5'd31, 32'h80000000}, // R8
    '{4'd4, 32'h12345678, 32'hFFFFFFFF, 5'd4,  32'h23456780}, // R8
    '{4'd4, 32'h0000ABCD, 32'h00000007, 5'd0,  32'h0000ABCD}, // R8
    '{4'd5, 32'h80000000, 32'h12345678, 5'd31, 32'h00000001}, // R9
    '{4'd5, 32'hF0000000, 32'hFFFFFFFF, 5'd4,  32'h0F000000}, // R9
    '{4'd9, 32'hF0000000, 32'h00000001, 5'd4,  32'hFF000000}, // R10
    '{4'd9, 32'h80000000, 32'hFFFFFFFF, 5'd31, 32'hFFFFFFFF}, // R10
    '{4'd9, 32'h70000000, 32'h00000000, 5'd4,  32'h07000000}, // R10
    '{4'd10, 32'hFFFFFFFF, 32'hFFFFFFFF, 5'd7, 32'h00000000}  // R11
  };

  logic         clk;
  logic [W-1:0] a, b, res;
  logic [4:0]   sh;
  logic [3:0]   op;
  logic         zero;
  int           errors = 0;
  int           checks = 0;
  bit           done = 0;

  int_alu uut (
    .a_i(a), .b_i(b), .shamt_i(sh), .op_i(op),
    .result_o(res), .zero_o(zero)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic apply(input logic [3:0] o, input logic [W-1:0] x,
                       input logic [W-1:0] y, input logic [4:0] s);
    @(negedge clk);
    op = o; a = x; b = y; sh = s;
    #2;
  endtask

  task automatic check(input string req, input logic [W-1:0] exp);
    checks++;
    if (res !== exp) begin
      errors++;
      $display("FAIL %s op=%0d result actual=%h expected=%h", req, op, res, exp);
    end
    checks++;
    if (zero !== (exp == '0)) begin
      errors++;
      $display("FAIL R12 (%s) op=%0d zero actual=%b expected=%b", req, op, zero, exp == '0);
    end
  endtask

  initial begin
    #1000000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    op = '0; a = '0; b = '0; sh = '0;
    // idle state: all-zero inputs give a zero result with the flag set (R1, R12)
    apply(4'd0, '0, '0, '0);
    check("R1_idle", '0);

    for (int i = 0; i < NV; i++) begin
      apply(VEC[i].op, VEC[i].a, VEC[i].b, VEC[i].sh);
      check($sformatf("vec%0d", i), VEC[i].exp);
    end

    // R8 R9 R10: every shift count, B nonzero and ignored
    for (int s = 0; s < 32; s++) begin
      apply(4'd4, 32'h9ABC_DEF1, 32'h5555_5555, 5'(s));
      check("R8", 32'h9ABC_DEF1 << s);
      apply(4'd5, 32'h9ABC_DEF1, 32'hAAAA_AAAA, 5'(s));
      check("R9", 32'h9ABC_DEF1 >> s);
      apply(4'd9, 32'h9ABC_DEF1, 32'h1234_5678, 5'(s));
      check("R10", 32'($signed(32'h9ABC_DEF1) >>> s));
    end

    // R11: each unused code with busy operands
    for (int c = 10; c < 16; c++) begin
      apply(4'(c), 32'hDEAD_BEEF, 32'h0000_0001, 5'd13);
      check("R11", '0);
    end

    // R12: equality via subtract, unequal by one bit
    apply(4'd6, 32'h8000_0000, 32'h8000_0000, 5'd0);
    check("R12", '0);
    apply(4'd6, 32'h8000_0001, 32'h8000_0000, 5'd0);
    check("R12", 32'h0000_0001);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule